// File: doc/BRIEF.md
# Security Violation Reset Controller

This block turns a set of security-violation request lines into one system reset request. Each line can be blocked on its own by a mask register, and a global block bit can stop the security source from resetting the system at all. Unblocked requests are combined into a single request. That request is treated either as a one-shot event, where a request that stays asserted causes a single reset, or as a level, where a request that stays asserted keeps resetting the system. Every reset the block issues is driven low on an active-low output for a fixed minimum of 16 clock cycles.

The block keeps cause registers that the generated reset does not clear. Only the block's own power-on reset `rst_ni` clears them. Software can therefore find out, after the system comes back, that a security reset happened and which lines raised it. The registers sit on a small word-addressed register bus. Only accesses marked secure are accepted.

Register map (word address on `reg_addr_i`):
- 0, control: bit 0 = global block, bit 1 = one-shot mode.
- 1, line mask: bit i blocks line i.
- 2, cause: bit 9 (0x200) = security reset occurred. Write 1 to clear.
- 3, line cause: bit i = line i was part of a triggering request. Write 1 to clear.

Top module: `sec_rst_ctrl`

## Requirements
- R1: After `rst_ni`, `sys_rst_no` is high, control reads 0x2 (one-shot on, global block off), and the line mask, cause and line cause registers read 0.
- R2: An unblocked violation on any line, sampled at a clock edge, drives `sys_rst_no` low from that edge for exactly 16 cycles, whatever the width of the violation pulse.
- R3: With control bit 1 = 1 (one-shot), a request held high gives exactly one reset. A further reset needs the combined request to be low for at least one cycle first.
- R4: With control bit 1 = 0 (level), a request held high issues reset after reset, and `sys_rst_no` returns high for exactly one cycle between them.
- R5: With control bit 0 = 1 (global block), no violation causes a reset, and no cause bit is set.
- R6: Setting bit i of the line mask (address 1) stops line i from causing a reset or setting a cause bit. Unmasked lines still trigger.
- R7: Each issued reset sets cause bit 9 (0x200). It also sets, in the same cycle, the line cause bit of every unmasked line that is asserted in the triggering cycle.
- R8: Cause bits are cleared only by writing 1 to them (a 0 leaves them unchanged) or by `rst_ni`. They survive the reset the block drives.
- R9: Writes with `reg_secure_i` = 0 change no register, and reads with `reg_secure_i` = 0 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset, clears all state |
| viol_i | input | N_SRC | Violation request lines, active high |
| reg_valid_i | input | 1 | Register access valid |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_secure_i | input | 1 | Access comes from the secure world |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational, 0 when no secure read is in progress |
| sys_rst_no | output | 1 | Active-low system reset request |

## Verification
If the armed state is stuck, the fault shows at `sys_rst_no` on the cycle after the request is sampled: either a held request causes a second fall, or a rearmed request causes none. A faulty stretch counter shows only at the rising edge, 16 cycles after the fall, as a low period of the wrong length. A wrong mask or cause capture shows on the next secure register read as a wrong bit pattern, or at the output as a reset that should have been blocked.

// File: rtl/sec_rst_pkg.sv
`timescale 1ns/1ps
package sec_rst_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL      = 2'd0,
    ADDR_SRC_MASK  = 2'd1,
    ADDR_CAUSE     = 2'd2,
    ADDR_SUB_CAUSE = 2'd3
  } reg_addr_e;

  localparam int CTRL_BLOCK_BIT   = 0;
  localparam int CTRL_ONESHOT_BIT = 1;
  localparam int CAUSE_SEC_BIT    = 9;
endpackage

// File: rtl/sec_rst_regs.sv
`timescale 1ns/1ps
module sec_rst_regs
  import sec_rst_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic              reg_secure_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              fire_i,
  input  logic [N_SRC-1:0]  hit_i,
  output logic              glb_block_o,
  output logic              oneshot_o,
  output logic [N_SRC-1:0]  src_mask_o,
  output logic              cause_sec_o
);
  logic             wr_en, rd_en;
  logic             wr_ctrl, wr_mask, wr_cause, wr_sub;
  logic [N_SRC-1:0] sub_cause_q;
  logic [N_SRC-1:0] sub_clr;
  logic             sec_clr;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  assign wr_en    = reg_valid_i & reg_write_i & reg_secure_i;
  assign rd_en    = reg_valid_i & ~reg_write_i & reg_secure_i;
  assign wr_ctrl  = wr_en & (reg_addr_i == ADDR_CTRL);
  assign wr_mask  = wr_en & (reg_addr_i == ADDR_SRC_MASK);
  assign wr_cause = wr_en & (reg_addr_i == ADDR_CAUSE);
  assign wr_sub   = wr_en & (reg_addr_i == ADDR_SUB_CAUSE);

  assign sec_clr = wr_cause & reg_wdata_i[CAUSE_SEC_BIT];
  assign sub_clr = wr_sub ? reg_wdata_i[N_SRC-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_block_o <= 1'b0;
      oneshot_o   <= 1'b1;
      src_mask_o  <= '0;
      cause_sec_o <= 1'b0;
      sub_cause_q <= '0;
    end else begin
      if (wr_ctrl) begin
        glb_block_o <= reg_wdata_i[CTRL_BLOCK_BIT];
        oneshot_o   <= reg_wdata_i[CTRL_ONESHOT_BIT];
      end
      if (wr_mask) src_mask_o <= reg_wdata_i[N_SRC-1:0];
      // capture wins over a same-cycle clear
      cause_sec_o <= fire_i | (cause_sec_o & ~sec_clr);
      sub_cause_q <= (fire_i ? hit_i : '0) | (sub_cause_q & ~sub_clr);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (rd_en) begin
      case (reg_addr_i)
        ADDR_CTRL: begin
          reg_rdata_o[CTRL_BLOCK_BIT]   = glb_block_o;
          reg_rdata_o[CTRL_ONESHOT_BIT] = oneshot_o;
        end
        ADDR_SRC_MASK:  reg_rdata_o[N_SRC-1:0]    = src_mask_o;
        ADDR_CAUSE:     reg_rdata_o[CAUSE_SEC_BIT] = cause_sec_o;
        default:        reg_rdata_o[N_SRC-1:0]    = sub_cause_q;
      endcase
    end
  end
endmodule

// File: rtl/sec_rst_trigger.sv
`timescale 1ns/1ps
module sec_rst_trigger #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] viol_i,
  input  logic [N_SRC-1:0] src_mask_i,
  input  logic             glb_block_i,
  input  logic             oneshot_i,
  input  logic             busy_i,
  output logic [N_SRC-1:0] hit_o,
  output logic             fire_o,
  output logic             armed_o
);
  logic req;

  assign hit_o  = viol_i & ~src_mask_i;
  assign req    = (|hit_o) & ~glb_block_i;
  assign fire_o = req & ~busy_i & (armed_o | ~oneshot_i);

  // disarm on issue, rearm once the combined request is seen low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_o <= 1'b1;
    else if (fire_o)  armed_o <= 1'b0;
    else if (!req)    armed_o <= 1'b1;
  end
endmodule

// File: rtl/sec_rst_stretch.sv
`timescale 1ns/1ps
module sec_rst_stretch #(
  parameter int STRETCH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o,
  output logic rst_no
);
  localparam int CNT_W = (STRETCH > 1) ? $clog2(STRETCH) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (active_o) begin
      if (cnt_q == '0) active_o <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end else if (fire_i) begin
      active_o <= 1'b1;
      cnt_q    <= CNT_W'(STRETCH - 1);
    end
  end

  assign rst_no = ~active_o;
endmodule

// File: rtl/sec_rst_ctrl.sv
`timescale 1ns/1ps
module sec_rst_ctrl
  import sec_rst_pkg::*;
#(
  parameter int N_SRC   = 8,
  parameter int STRETCH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  viol_i,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic              reg_secure_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              sys_rst_no
);
  logic             glb_block, oneshot, cause_sec;
  logic [N_SRC-1:0] src_mask, hit;
  logic             fire, armed, active;

  sec_rst_regs #(.N_SRC(N_SRC)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_valid_i  (reg_valid_i),
    .reg_write_i  (reg_write_i),
    .reg_secure_i (reg_secure_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .fire_i       (fire),
    .hit_i        (hit),
    .glb_block_o  (glb_block),
    .oneshot_o    (oneshot),
    .src_mask_o   (src_mask),
    .cause_sec_o  (cause_sec)
  );

  sec_rst_trigger #(.N_SRC(N_SRC)) u_trig (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .viol_i      (viol_i),
    .src_mask_i  (src_mask),
    .glb_block_i (glb_block),
    .oneshot_i   (oneshot),
    .busy_i      (active),
    .hit_o       (hit),
    .fire_o      (fire),
    .armed_o     (armed)
  );

  sec_rst_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .active_o (active),
    .rst_no   (sys_rst_no)
  );
endmodule

// File: rtl/sec_rst_ctrl_chk.sv
`timescale 1ns/1ps
module sec_rst_ctrl_chk #(
  parameter int N_SRC   = 8,
  parameter int STRETCH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sys_rst_no,
  input logic             reg_valid_i,
  input logic             reg_write_i,
  input logic             reg_secure_i,
  input logic             glb_block,
  input logic             oneshot,
  input logic [N_SRC-1:0] src_mask,
  input logic             cause_sec,
  input logic             armed
);
  localparam int RUN_W = $clog2(STRETCH + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_run <= '0;
    else if (!sys_rst_no) low_run <= (low_run == RUN_MAX) ? low_run : low_run + 1'b1;
    else                  low_run <= '0;
  end

  AST_STRETCH_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> (low_run == RUN_W'(STRETCH))); // R2

  AST_STRETCH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_run <= RUN_W'(STRETCH)); // R2

  AST_ONESHOT_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sys_rst_no) && $past(oneshot)) |-> $past(armed)); // R3

  AST_GLOBAL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_no) |-> !$past(glb_block)); // R5

  AST_CAUSE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_no) |-> cause_sec); // R7

  AST_NS_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && reg_write_i && !reg_secure_i) |=>
      ($stable(src_mask) && $stable(glb_block) && $stable(oneshot))); // R9
endmodule

bind sec_rst_ctrl sec_rst_ctrl_chk #(.N_SRC(N_SRC), .STRETCH(STRETCH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sys_rst_no   (sys_rst_no),
  .reg_valid_i  (reg_valid_i),
  .reg_write_i  (reg_write_i),
  .reg_secure_i (reg_secure_i),
  .glb_block    (glb_block),
  .oneshot      (oneshot),
  .src_mask     (src_mask),
  .cause_sec    (cause_sec),
  .armed        (armed)
);

// File: tb/sec_rst_ctrl_bench.sv
`timescale 1ns/1ps
module sec_rst_ctrl_bench;
  localparam int N_SRC   = 8;
  localparam int STRETCH = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_SRC-1:0] viol_i = '0;
  logic             reg_valid_i = 1'b0, reg_write_i = 1'b0, reg_secure_i = 1'b0;
  logic [1:0]       reg_addr_i = '0;
  logic [31:0]      reg_wdata_i = '0;
  logic [31:0]      reg_rdata_o;
  logic             sys_rst_no;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  always #2 clk_i = ~clk_i;

  sec_rst_ctrl #(.N_SRC(N_SRC), .STRETCH(STRETCH)) u_sec_rst_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .viol_i(viol_i),
    .reg_valid_i(reg_valid_i), .reg_write_i(reg_write_i), .reg_secure_i(reg_secure_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .sys_rst_no(sys_rst_no)
  );

  function automatic logic [31:0] exp_sub(input logic [N_SRC-1:0] v, input logic [N_SRC-1:0] m);
    return 32'(v & ~m);
  endfunction

  function automatic int exp_lows(input logic [31:0] hits);
    return (hits != 0) ? STRETCH : 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d, input logic sec);
    @(negedge clk_i);
    reg_valid_i = 1'b1; reg_write_i = 1'b1; reg_secure_i = sec;
    reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_valid_i = 1'b0; reg_write_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, input logic sec, output logic [31:0] d);
    @(negedge clk_i);
    reg_valid_i = 1'b1; reg_write_i = 1'b0; reg_secure_i = sec; reg_addr_i = a;
    #1 d = reg_rdata_o;
    reg_valid_i = 1'b0;
  endtask

  task automatic run(input logic [N_SRC-1:0] vec, input int width, input int total,
                     output int lows, output int falls, output int first);
    logic prev;
    lows = 0; falls = 0; first = -1;
    @(negedge clk_i);
    viol_i = vec;
    prev = sys_rst_no;
    for (int i = 1; i <= total; i++) begin
      @(negedge clk_i);
      if (!sys_rst_no) begin
        lows++;
        if (first < 0) first = i;
      end
      if (prev && !sys_rst_no) falls++;
      prev = sys_rst_no;
      if (i == width) viol_i = '0;
    end
    viol_i = '0;
    repeat (20) @(negedge clk_i);
  endtask

  task automatic clear_causes();
    reg_wr(2'd2, 32'h200, 1'b1);
    reg_wr(2'd3, 32'hFFFF_FFFF, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int lows, falls, first;
    void'($urandom(32'd4711));

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 rst out", 32'(sys_rst_no), 32'd1);
    reg_rd(2'd0, 1'b1, rd); chk("R1 ctrl", rd, 32'h2);
    reg_rd(2'd1, 1'b1, rd); chk("R1 mask", rd, 32'h0);
    reg_rd(2'd2, 1'b1, rd); chk("R1 cause", rd, 32'h0);
    reg_rd(2'd3, 1'b1, rd); chk("R1 sub", rd, 32'h0);

    // R2 one-cycle pulse stretched to 16
    run(8'h08, 1, 30, lows, falls, first);
    chk("R2 first low", 32'(first), 32'd1);
    chk("R2 low len", 32'(lows), 32'd16);
    chk("R2 falls", 32'(falls), 32'd1);
    // R7 cause capture, R8 survives issued reset
    reg_rd(2'd2, 1'b1, rd); chk("R7 R8 cause", rd, 32'h200);
    reg_rd(2'd3, 1'b1, rd); chk("R7 sub", rd, 32'h08);

    // R8 write-1-to-clear
    reg_wr(2'd2, 32'h0, 1'b1);
    reg_rd(2'd2, 1'b1, rd); chk("R8 w0 keeps", rd, 32'h200);
    reg_wr(2'd2, 32'h200, 1'b1);
    reg_rd(2'd2, 1'b1, rd); chk("R8 w1 clears", rd, 32'h0);
    reg_wr(2'd3, 32'h08, 1'b1);
    reg_rd(2'd3, 1'b1, rd); chk("R8 sub clear", rd, 32'h0);

    // R3 held request in one-shot mode, then rearm after release
    run(8'h01, 60, 60, lows, falls, first);
    chk("R3 held falls", 32'(falls), 32'd1);
    chk("R3 held lows", 32'(lows), 32'd16);
    run(8'h01, 1, 30, lows, falls, first);
    chk("R3 rearm falls", 32'(falls), 32'd1);

    // R4 level mode: 16 low, 1 high, repeated
    reg_wr(2'd0, 32'h0, 1'b1);
    run(8'h02, 60, 60, lows, falls, first);
    chk("R4 level falls", 32'(falls), 32'd4);
    chk("R4 level lows", 32'(lows), 32'd57);
    clear_causes();

    // R5 global block
    reg_wr(2'd0, 32'h3, 1'b1);
    run(8'hFF, 5, 30, lows, falls, first);
    chk("R5 falls", 32'(falls), 32'd0);
    reg_rd(2'd2, 1'b1, rd); chk("R5 cause", rd, 32'h0);
    reg_rd(2'd3, 1'b1, rd); chk("R5 sub", rd, 32'h0);

    // R6 per-line mask
    reg_wr(2'd0, 32'h2, 1'b1);
    reg_wr(2'd1, 32'h04, 1'b1);
    run(8'h04, 3, 30, lows, falls, first);
    chk("R6 masked falls", 32'(falls), 32'd0);
    reg_rd(2'd2, 1'b1, rd); chk("R6 masked cause", rd, 32'h0);
    run(8'h20, 3, 30, lows, falls, first);
    chk("R6 other falls", 32'(falls), 32'd1);
    clear_causes();

    // R7 several lines together, one masked
    reg_wr(2'd1, 32'h10, 1'b1);
    run(8'h52, 2, 30, lows, falls, first);
    chk("R7 multi falls", 32'(falls), 32'd1);
    reg_rd(2'd3, 1'b1, rd); chk("R7 multi sub", rd, 32'h42);
    reg_rd(2'd2, 1'b1, rd); chk("R7 multi cause", rd, 32'h200);

    // R9 non-secure accesses
    reg_wr(2'd0, 32'h1, 1'b0);
    reg_wr(2'd1, 32'hFF, 1'b0);
    reg_wr(2'd2, 32'h200, 1'b0);
    reg_rd(2'd0, 1'b1, rd); chk("R9 ctrl kept", rd, 32'h2);
    reg_rd(2'd1, 1'b1, rd); chk("R9 mask kept", rd, 32'h10);
    reg_rd(2'd2, 1'b1, rd); chk("R9 cause kept", rd, 32'h200);
    reg_rd(2'd2, 1'b0, rd); chk("R9 ns read", rd, 32'h0);
    clear_causes();

    // random one-shot traffic (R2 R6 R7)
    for (int k = 0; k < 24; k++) begin
      logic [N_SRC-1:0] m, v;
      int w;
      logic [31:0] h;
      m = N_SRC'($urandom);
      v = N_SRC'($urandom);
      w = 1 + int'($urandom % 20);
      h = exp_sub(v, m);
      reg_wr(2'd1, 32'(m), 1'b1);
      run(v, w, w + 20, lows, falls, first);
      chk("R2 rnd lows", 32'(lows), 32'(exp_lows(h)));
      chk("R6 rnd falls", 32'(falls), (h != 0) ? 32'd1 : 32'd0);
      reg_rd(2'd3, 1'b1, rd); chk("R7 rnd sub", rd, h);
      reg_rd(2'd2, 1'b1, rd); chk("R7 rnd cause", rd, (h != 0) ? 32'h200 : 32'h0);
      clear_causes();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule